// File: doc/BRIEF.md
# Signed Complex Adder Tree

This block sums a parameterized number of complex operands, each carried as separate signed real and imaginary fields of a common width. Every operand has its own sign, taken from a sign string parameter, so the result is a signed combination such as a - b - c + d + e. The sum is formed by a binary tree of two-input complex add/subtract nodes. Only the first tree level applies operand signs. Every later level is a plain adder, and the real and imaginary fields run through two identical trees that do not interact.

When pipelining is enabled, each tree level ends in a register, so the result appears after ceil(log2(N)) captures. A repeating phase mask parameter decides on which clock cycles those registers capture. An optional clock enable gates every capture, and an optional asynchronous clear empties the pipeline and restarts the phase sequence. When pipelining is disabled, the path from the operands to the result is purely combinational.

Top module: `cplx_signed_sum`

## Requirements
- R1: The parameters are checked during elaboration. NUM_IN below 2 is an error. A sign string longer than NUM_IN, or one holding any character other than '+' and '-', is an error. A first-level pair (ports 2k and 2k+1) whose signs are both '-' is an error. A pattern such as "+--++" is legal, because its two '-' fall in different pairs.
- R2: Character i of SIGNS, counted from the left starting at 0, sets the sign of port i. '-' subtracts that port and '+' adds it. Ports beyond the end of the string count as '+'. With the string "-+" and NUM_IN=3, the result is -a + b + c.
- R3: When NUM_IN is odd, the last port has no partner at the first level and passes through that level alone. It is negated there if its sign is '-'. With "+--" and NUM_IN=3, the result is a - b - c.
- R4: Each output is DW + ceil(log2(NUM_IN)) bits wide, signed. No combination of full-scale inputs can overflow it.
- R5: The imaginary result depends only on the imaginary inputs, and the real result only on the real inputs.
- R6: With PIPE=1, the result of an operand set captured on one load appears on the outputs after the third load in total for NUM_IN=5, or generally after ceil(log2(NUM_IN)) loads. Before it appears, the outputs show earlier sums, or zero after a clear. With PIPE=0, the outputs follow the inputs with no clock.
- R7: PHASE_MASK is a string of '1'/'0' of length L. A phase counter steps through 0..L-1 on every clock and wraps. Character 0 (leftmost) belongs to the first clock edge after a clear. Registers load only on edges whose mask character is '1'; on the other edges the outputs hold. With "10", loads happen on the 1st, 3rd, 5th... edges.
- R8: With USE_ENA=1, a low ena blocks every load and the outputs hold. The phase counter keeps advancing while ena is low.
- R9: With USE_ACLR=1, a high aclr zeroes all tree registers and the phase counter at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| aclr | input | 1 | Asynchronous clear, active high (used when USE_ACLR=1) |
| ena | input | 1 | Clock enable for all tree registers (used when USE_ENA=1) |
| in_re | input | NUM_IN*DW | Real parts; port j occupies bits j*DW +: DW, signed |
| in_im | input | NUM_IN*DW | Imaginary parts, same layout as in_re |
| out_re | output | DW+ceil(log2(NUM_IN)) | Signed real part of the result |
| out_im | output | DW+ceil(log2(NUM_IN)) | Signed imaginary part of the result |

## Verification
The clock enable and the phase mask can both decide the same edge. A low ena can land on a mask '1' phase and must suppress that load, while the phase counter still moves on. Random ena toggling drives this case, and a bench model that advances its own phase on every edge judges it: after ena returns, the model shows whether the capture lands on the right edge. The clear can also arrive in the middle of the phase sequence. The bench raises it between edges, checks the outputs drop to zero before the next edge, and then expects capture to restart on the first mask phase.

// File: rtl/csum_pkg.sv
package csum_pkg;
   // number of live terms after a given tree level
   function automatic int terms_at_level(int n, int lvl);
      return (n + (1 << lvl) - 1) >> lvl;
   endfunction

   localparam logic [7:0] CH_PLUS  = "+";
   localparam logic [7:0] CH_MINUS = "-";
   localparam logic [7:0] CH_ONE   = "1";
   localparam logic [7:0] CH_ZERO  = "0";
endpackage

// File: rtl/csum_node.sv
module csum_node #(
   parameter int W     = 8,
   parameter bit NEG_A = 1'b0,
   parameter bit NEG_B = 1'b0
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y
);
   logic signed [W-1:0] ta, tb;

   // R1: a node never subtracts both operands
   if (NEG_A && NEG_B) begin : g_bad_pair
      $error("csum_node: both operands of a first-level pair are negated");
   end

   if (NEG_A) begin : g_na
      assign ta = -a;
   end else begin : g_pa
      assign ta = a;
   end

   if (NEG_B) begin : g_nb
      assign tb = -b;
   end else begin : g_pb
      assign tb = b;
   end

   assign y = ta + tb;
endmodule

// File: rtl/csum_stage_reg.sv
module csum_stage_reg #(
   parameter int W    = 8,
   parameter bit PIPE = 1'b1
) (
   input  logic                clk,
   input  logic                clr,
   input  logic                load,
   input  logic signed [W-1:0] d,
   output logic signed [W-1:0] q
);
   if (PIPE) begin : g_reg
      always_ff @(posedge clk or posedge clr) begin
         if (clr)
            q <= '0;
         else if (load)
            q <= d;
      end
   end else begin : g_wire
      assign q = d;
   end
endmodule

// File: rtl/csum_phase_gen.sv
module csum_phase_gen
   import csum_pkg::*;
#(
   parameter MASK        = "1",
   parameter bit USE_ENA = 1'b1,
   localparam int L      = $bits(MASK) / 8,
   localparam int PW     = (L > 1) ? $clog2(L) : 1
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          ena,
   output logic          load_o,
   output logic [PW-1:0] phase_o
);
   function automatic logic [L-1:0] mask_bits();
      logic [L-1:0] m = '0;
      for (int i = 0; i < L; i++)
         m[i] = (MASK[8*(L-1-i) +: 8] == CH_ONE);
      return m;
   endfunction

   function automatic int bad_mask_chars();
      int n = 0;
      for (int i = 0; i < L; i++) begin
         logic [7:0] c = MASK[8*(L-1-i) +: 8];
         if (c != CH_ONE && c != CH_ZERO) n++;
      end
      return n;
   endfunction

   localparam logic [L-1:0] MBITS = mask_bits();

   if (($bits(MASK) % 8) != 0 || L < 1 || bad_mask_chars() != 0) begin : g_bad_mask
      $error("csum_phase_gen: phase mask must be a non-empty string of 0/1");
   end

   logic          ena_eff;
   logic [PW-1:0] phase_q;

   if (USE_ENA) begin : g_ena
      assign ena_eff = ena;
   end else begin : g_noena
      assign ena_eff = 1'b1;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr)
         phase_q <= '0;
      else if (phase_q == PW'(L - 1))
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign load_o  = ena_eff & MBITS[phase_q];
   assign phase_o = phase_q;
endmodule

// File: rtl/csum_tree.sv
module csum_tree
   import csum_pkg::*;
#(
   parameter int NUM_IN             = 2,
   parameter int W_IN               = 8,
   parameter int W_OUT              = 9,
   parameter logic [NUM_IN-1:0] NEG = '0,
   parameter bit PIPE               = 1'b1
) (
   input  logic                     clk,
   input  logic                     clr,
   input  logic                     load,
   input  logic [NUM_IN*W_IN-1:0]   in_flat,
   output logic signed [W_OUT-1:0]  sum_o
);
   localparam int LEVELS = $clog2(NUM_IN);

   function automatic bit neg_at(int idx);
      return (idx < NUM_IN) ? NEG[idx] : 1'b0;
   endfunction

   logic signed [W_OUT-1:0] term [LEVELS+1][NUM_IN];

   for (genvar j = 0; j < NUM_IN; j++) begin : g_leaf
      assign term[0][j] = W_OUT'(signed'(in_flat[j*W_IN +: W_IN]));
   end

   for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
      localparam int N_PREV = terms_at_level(NUM_IN, k - 1);
      localparam int N_CUR  = terms_at_level(NUM_IN, k);
      for (genvar j = 0; j < NUM_IN; j++) begin : g_slot
         if (j < N_CUR) begin : g_used
            localparam bit PAIRED = (2*j + 1) < N_PREV;
            localparam bit NA     = (k == 1) && neg_at(2*j);
            localparam bit NB     = (k == 1) && PAIRED && neg_at(2*j + 1);
            logic signed [W_OUT-1:0] b_in, sum_c;
            if (PAIRED) begin : g_pair
               assign b_in = term[k-1][2*j+1];
            end else begin : g_single
               assign b_in = '0;
            end
            csum_node #(.W(W_OUT), .NEG_A(NA), .NEG_B(NB)) u_node (
               .a(term[k-1][2*j]), .b(b_in), .y(sum_c));
            csum_stage_reg #(.W(W_OUT), .PIPE(PIPE)) u_reg (
               .clk(clk), .clr(clr), .load(load), .d(sum_c), .q(term[k][j]));
         end else begin : g_idle
            assign term[k][j] = '0;
         end
      end
   end

   assign sum_o = term[LEVELS][0];
endmodule

// File: rtl/cplx_signed_sum.sv
module cplx_signed_sum
   import csum_pkg::*;
#(
   parameter int NUM_IN   = 5,
   parameter int DW       = 16,
   parameter SIGNS        = "+--++",
   parameter bit PIPE     = 1'b1,
   parameter PHASE_MASK   = "10",
   parameter bit USE_ENA  = 1'b1,
   parameter bit USE_ACLR = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 aclr,
   input  logic                                 ena,
   input  logic [NUM_IN*DW-1:0]                 in_re,
   input  logic [NUM_IN*DW-1:0]                 in_im,
   output logic signed [DW+$clog2(NUM_IN)-1:0]  out_re,
   output logic signed [DW+$clog2(NUM_IN)-1:0]  out_im
);
   localparam int OW     = DW + $clog2(NUM_IN);
   localparam int SLEN   = $bits(SIGNS) / 8;
   localparam int PH_LEN = $bits(PHASE_MASK) / 8;
   localparam int PH_W   = (PH_LEN > 1) ? $clog2(PH_LEN) : 1;

   function automatic logic [NUM_IN-1:0] decode_signs();
      logic [NUM_IN-1:0] v = '0;
      for (int i = 0; i < NUM_IN; i++)
         if (i < SLEN)
            if (SIGNS[8*(SLEN-1-i) +: 8] == CH_MINUS) v[i] = 1'b1;
      return v;
   endfunction

   function automatic int bad_sign_chars();
      int n = 0;
      for (int i = 0; i < SLEN; i++) begin
         logic [7:0] c = SIGNS[8*(SLEN-1-i) +: 8];
         if (c != CH_PLUS && c != CH_MINUS) n++;
      end
      return n;
   endfunction

   localparam logic [NUM_IN-1:0] NEG_VEC = decode_signs();

   // R1: parameter legality
   if (NUM_IN < 2) begin : g_bad_n
      $error("cplx_signed_sum: NUM_IN must be at least 2");
   end
   if (($bits(SIGNS) % 8) != 0 || SLEN > NUM_IN || bad_sign_chars() != 0) begin : g_bad_signs
      $error("cplx_signed_sum: sign string must hold at most NUM_IN of + and -");
   end

   logic            clr_i;
   logic            load_en;
   logic [PH_W-1:0] phase_idx;

   if (USE_ACLR) begin : g_clr
      assign clr_i = aclr;
   end else begin : g_noclr
      assign clr_i = 1'b0;
   end

   csum_phase_gen #(.MASK(PHASE_MASK), .USE_ENA(USE_ENA)) u_phase (
      .clk(clk), .clr(clr_i), .ena(ena), .load_o(load_en), .phase_o(phase_idx));

   logic [NUM_IN*DW-1:0] part_in  [2];
   logic signed [OW-1:0] part_out [2];

   assign part_in[0] = in_re;
   assign part_in[1] = in_im;

   // R5: one independent tree per component
   for (genvar p = 0; p < 2; p++) begin : g_part
      csum_tree #(.NUM_IN(NUM_IN), .W_IN(DW), .W_OUT(OW), .NEG(NEG_VEC), .PIPE(PIPE)) u_tree (
         .clk(clk), .clr(clr_i), .load(load_en), .in_flat(part_in[p]), .sum_o(part_out[p]));
   end

   assign out_re = part_out[0];
   assign out_im = part_out[1];
endmodule

// File: rtl/csum_checker.sv
module csum_checker #(
   parameter int OW       = 8,
   parameter int L        = 1,
   parameter int PW       = 1,
   parameter bit PIPE     = 1'b1,
   parameter bit USE_ENA  = 1'b1,
   parameter bit USE_ACLR = 1'b1
) (
   input logic                 clk,
   input logic                 aclr,
   input logic                 ena,
   input logic                 load,
   input logic [PW-1:0]        phase,
   input logic signed [OW-1:0] out_re,
   input logic signed [OW-1:0] out_im
);
   // R7: phase counter wraps at the end of the mask
   a_r7_phase_wrap: assert property (@(posedge clk) disable iff (aclr)
      (phase == PW'(L - 1)) |=> (phase == '0));

   // R7: phase counter steps by one otherwise
   a_r7_phase_step: assert property (@(posedge clk) disable iff (aclr)
      (phase != PW'(L - 1)) |=> (phase == $past(phase) + 1'b1));

   if (PIPE) begin : g_pipe
      // R7 R8: no load, no change at the outputs
      a_r7_hold: assert property (@(posedge clk) disable iff (aclr)
         !load |=> ($stable(out_re) && $stable(out_im)));
   end

   if (USE_ENA) begin : g_ena
      // R8: a low enable blocks every load
      a_r8_ena_gate: assert property (@(posedge clk) disable iff (aclr)
         !ena |-> !load);
   end

   if (USE_ACLR) begin : g_clr
      always @(posedge clk) begin
         if (aclr) begin
            // R9: clear holds registers and phase at zero
            a_r9_clear_state: assert (phase == '0 &&
               (!PIPE || (out_re == '0 && out_im == '0)));
         end
      end
   end
endmodule

bind cplx_signed_sum csum_checker #(
   .OW(OW), .L(PH_LEN), .PW(PH_W), .PIPE(PIPE), .USE_ENA(USE_ENA), .USE_ACLR(USE_ACLR)
) u_chk (
   .clk(clk), .aclr(aclr), .ena(ena), .load(load_en), .phase(phase_idx),
   .out_re(out_re), .out_im(out_im)
);

// File: tb/cplx_signed_sum_tb_top.sv
module cplx_signed_sum_tb_top;
   localparam logic [4:0] NEG5  = 5'b00110; // "+--++": ports 1 and 2 subtract
   localparam logic [2:0] NEG_A = 3'b001;   // "-+" with port 2 defaulted to '+'
   localparam logic [2:0] NEG_B = 3'b110;   // "+--": port 2 alone, negated

   logic clk = 1'b0;
   logic aclr = 1'b1;
   logic ena = 1'b0;
   always #10 clk = ~clk;

   logic signed [15:0] a_re [5];
   logic signed [15:0] a_im [5];
   logic [79:0] in_re, in_im;
   logic signed [18:0] out_re, out_im;

   logic signed [7:0] c_re [3];
   logic signed [7:0] c_im [3];
   logic [23:0] cin_re, cin_im;
   logic signed [9:0] oa_re, oa_im, ob_re, ob_im;

   always_comb begin
      for (int j = 0; j < 5; j++) begin
         in_re[j*16 +: 16] = a_re[j];
         in_im[j*16 +: 16] = a_im[j];
      end
      for (int j = 0; j < 3; j++) begin
         cin_re[j*8 +: 8] = c_re[j];
         cin_im[j*8 +: 8] = c_im[j];
      end
   end

   cplx_signed_sum dut_i (.clk(clk), .aclr(aclr), .ena(ena), .in_re(in_re), .in_im(in_im),
      .out_re(out_re), .out_im(out_im));

   cplx_signed_sum #(.NUM_IN(3), .DW(8), .SIGNS("-+"), .PIPE(1'b0)) dut_comb_a (
      .clk(clk), .aclr(aclr), .ena(ena), .in_re(cin_re), .in_im(cin_im),
      .out_re(oa_re), .out_im(oa_im));

   cplx_signed_sum #(.NUM_IN(3), .DW(8), .SIGNS("+--"), .PIPE(1'b0)) dut_comb_b (
      .clk(clk), .aclr(aclr), .ena(ena), .in_re(cin_re), .in_im(cin_im),
      .out_re(ob_re), .out_im(ob_im));

   int n_chk = 0;
   int n_fail = 0;
   int ph_tb = 0;
   longint q_re [3];
   longint q_im [3];
   string tag;

   function automatic longint ref5(input logic signed [15:0] v [5]);
      longint s = 0;
      for (int i = 0; i < 5; i++) s += NEG5[i] ? -longint'(v[i]) : longint'(v[i]);
      return s;
   endfunction

   function automatic longint ref3(input logic signed [7:0] v [3], input logic [2:0] neg);
      longint s = 0;
      for (int i = 0; i < 3; i++) s += neg[i] ? -longint'(v[i]) : longint'(v[i]);
      return s;
   endfunction

   task automatic check(input bit ok, input string t, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic clear_model();
      for (int i = 0; i < 3; i++) begin
         q_re[i] = 0;
         q_im[i] = 0;
      end
      ph_tb = 0;
   endtask

   // one clock: inputs already driven at the preceding negedge
   task automatic tick();
      bit ld;
      longint pre_re, pre_im;
      ld = ena && (ph_tb == 0);   // mask "10": phase 0 loads
      pre_re = out_re;
      pre_im = out_im;
      if (ld) begin
         q_re[2] = q_re[1]; q_re[1] = q_re[0]; q_re[0] = ref5(a_re);
         q_im[2] = q_im[1]; q_im[1] = q_im[0]; q_im[0] = ref5(a_im);
      end
      @(posedge clk);
      ph_tb = (ph_tb + 1) % 2;
      @(negedge clk);
      check(longint'(out_re) == q_re[2], {tag, " real"}, out_re, q_re[2]);
      check(longint'(out_im) == q_im[2], {tag, " imag"}, out_im, q_im[2]);
      if (!ld) check(longint'(out_re) == pre_re && longint'(out_im) == pre_im,
                     "R7 R8 hold", out_re, pre_re);
   endtask

   task automatic rand_inputs();
      for (int j = 0; j < 5; j++) begin
         a_re[j] = 16'($urandom);
         a_im[j] = 16'($urandom);
      end
   endtask

   task automatic comb_check(input string t);
      #1;
      check(longint'(oa_re) == ref3(c_re, NEG_A), {t, " R2 comb_a real"}, oa_re, ref3(c_re, NEG_A));
      check(longint'(oa_im) == ref3(c_im, NEG_A), {t, " R2 comb_a imag"}, oa_im, ref3(c_im, NEG_A));
      check(longint'(ob_re) == ref3(c_re, NEG_B), {t, " R3 comb_b real"}, ob_re, ref3(c_re, NEG_B));
      check(longint'(ob_im) == ref3(c_im, NEG_B), {t, " R3 comb_b imag"}, ob_im, ref3(c_im, NEG_B));
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd7345));
      for (int j = 0; j < 5; j++) begin a_re[j] = '0; a_im[j] = '0; end
      for (int j = 0; j < 3; j++) begin c_re[j] = '0; c_im[j] = '0; end
      clear_model();
      repeat (3) @(negedge clk);
      check(out_re == 0 && out_im == 0, "R9 reset state", out_re, 0);

      // combinational variants: R6 (PIPE=0), R2 defaulted sign, R3 odd port negated
      for (int j = 0; j < 3; j++) begin c_re[j] = 8'sd10 * 8'(j + 1); c_im[j] = -8'sd3; end
      comb_check("R6 directed");
      for (int j = 0; j < 3; j++) begin c_re[j] = -8'sd128; c_im[j] = 8'sd127; end
      comb_check("R4 extreme");
      for (int r = 0; r < 20; r++) begin
         for (int j = 0; j < 3; j++) begin c_re[j] = 8'($urandom); c_im[j] = 8'($urandom); end
         comb_check("R6 random");
      end

      // leave clear, capture starts on the first edge
      aclr = 1'b0;
      ena  = 1'b1;
      tag  = "R1 R2 R6 R7 directed";
      for (int j = 0; j < 5; j++) begin a_re[j] = 16'(100 * (j + 1)); a_im[j] = 16'(-7 * (j + 1)); end
      tick();
      for (int j = 0; j < 5; j++) begin a_re[j] = '0; a_im[j] = '0; end
      repeat (7) tick();
      for (int j = 0; j < 5; j++) begin a_re[j] = 16'(j + 1); a_im[j] = 16'(1 << j); end
      repeat (8) tick();

      // R4: full-scale operands against the sign pattern
      tag = "R4 extremes";
      for (int j = 0; j < 5; j++) begin
         a_re[j] = NEG5[j] ? 16'sh7fff : 16'sh8000;
         a_im[j] = NEG5[j] ? 16'sh8000 : 16'sh7fff;
      end
      repeat (8) tick();

      // R5: imaginary inputs zero while real ones vary
      tag = "R5 independence";
      for (int j = 0; j < 5; j++) begin a_re[j] = 16'(-1234 + 300 * j); a_im[j] = '0; end
      repeat (8) tick();
      check(out_im == 0, "R5 imag zero", out_im, 0);

      // R8: enable low, inputs change, outputs hold, phase keeps moving
      tag = "R8 enable low";
      ena = 1'b0;
      for (int c = 0; c < 5; c++) begin rand_inputs(); tick(); end
      ena = 1'b1;
      tag = "R8 after enable";
      repeat (6) tick();

      // mixed random with random enable
      tag = "R2 R6 R7 R8 random";
      for (int c = 0; c < 200; c++) begin
         rand_inputs();
         ena = ($urandom_range(3) != 0);
         tick();
      end

      // R9: asynchronous clear mid stream
      ena = 1'b1;
      for (int j = 0; j < 5; j++) begin a_re[j] = 16'sd500; a_im[j] = -16'sd20; end
      tag = "R9 preload";
      repeat (7) tick();
      aclr = 1'b1;
      #2;
      check(out_re == 0 && out_im == 0, "R9 async clear", out_re, 0);
      @(negedge clk);
      aclr = 1'b0;
      clear_model();
      tag = "R7 R9 restart";
      repeat (8) tick();

      summary();
      $finish;
   end
endmodule